// File: doc/BRIEF.md
# Write-Channel to Packet Bridge

This block sits on the slave side of a valid/ready write interface with three independent channels: address, data and response. For every write it produces one packet on a single network output. The first word of the packet is a header. The header is formed from the accepted address beat and carries four fields: a destination taken from the top address bits, the transaction ID, the beat count and the start address. The data beats that follow pass straight through as payload, with no buffering in the bridge.

The bridge keeps write-data ready low until the header word has been taken by the network side. A data beat that arrives before its address is therefore held by the master without deadlock, because address acceptance never depends on the data channel. Once the network has accepted the beat marked last, the bridge returns an OKAY response tagged with the ID of the write. It handles one write at a time and opens the address channel again only after the response handshake.

Top module: `wr2pkt_bridge`

## Requirements
- R1: During and directly after a synchronous active-high reset, aw_ready is 1, and w_ready, b_valid and pkt_valid are all 0.
- R2: An address beat is taken only in a cycle with aw_valid and aw_ready both high. From the next cycle, aw_ready stays low until the response handshake completes, even if aw_valid is high.
- R3: In the cycle after the address handshake, the bridge drives a header with pkt_valid=1, pkt_sop=1 and pkt_eop=0. The header holds the address in bits [31:0], aw_len in bits [39:32], the ID in bits [43:40] and address bits [31:28] in bits [47:44], with zeros above. It stays valid and unchanged until pkt_ready is sampled high.
- R4: w_ready is 0 from reset or idle until the header handshake, even when w_valid is high. A data beat raised before the address does not stop aw_ready.
- R5: In the payload phase, pkt_valid follows w_valid and pkt_data equals w_data in the same cycle, with pkt_sop=0 and w_ready equal to pkt_ready.
- R6: pkt_eop copies w_last on payload beats. In the cycle after the last beat is accepted, b_valid=1, b_id holds the captured ID and b_resp=2'b00 (OKAY).
- R7: b_valid and b_id stay unchanged while b_ready is low. After the response handshake, b_valid falls and aw_ready rises in the next cycle.
- R8: When pkt_ready is low in the payload phase, w_ready is low, so the master holds the beat and no payload word is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aw_valid | input | 1 | Address beat valid |
| aw_ready | output | 1 | Address beat accepted |
| aw_id | input | ID_W | Transaction ID |
| aw_addr | input | ADDR_W | Start address |
| aw_len | input | LEN_W | Beat count minus one |
| w_valid | input | 1 | Data beat valid |
| w_ready | output | 1 | Data beat accepted |
| w_data | input | DATA_W | Data word |
| w_last | input | 1 | Final data beat of the write |
| b_valid | output | 1 | Response valid |
| b_ready | input | 1 | Response accepted |
| b_id | output | ID_W | Response ID |
| b_resp | output | 2 | Response status |
| pkt_valid | output | 1 | Packet word valid |
| pkt_ready | input | 1 | Network accepts word |
| pkt_data | output | DATA_W | Header or payload word |
| pkt_sop | output | 1 | Word is the header |
| pkt_eop | output | 1 | Word ends the packet |

## Verification
If the phase register goes wrong, it shows on the ports in the same cycle. One symptom is w_ready opening while a header is still valid. Others are aw_ready coming back before the response completes, or b_valid rising without a preceding end-of-packet handshake. A corrupted address capture appears as soon as the header word is presented, one cycle after the address handshake. It shows again in b_id when the response is raised. The bench stalls each channel in turn, sends data before the address and holds the address valid during a response, so these faults show within a few cycles of the stimulus.

// File: rtl/wr2pkt_pkg.sv
package wr2pkt_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HEAD = 2'd1,
        PH_BODY = 2'd2,
        PH_RESP = 2'd3
    } wr_phase_e;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    localparam int unsigned DEF_ADDR_W = 32;
    localparam int unsigned DEF_DATA_W = 64;
    localparam int unsigned DEF_ID_W   = 4;
    localparam int unsigned DEF_LEN_W  = 8;
    localparam int unsigned DEF_DEST_W = 4;

    typedef struct packed {
        logic addr_take;
        logic head_take;
        logic tail_take;
        logic resp_take;
    } wr_events_t;

    function automatic wr_phase_e phase_step(input wr_phase_e cur, input wr_events_t ev);
        wr_phase_e nxt;
        nxt = cur;
        unique case (cur)
            PH_IDLE: if (ev.addr_take) nxt = PH_HEAD;
            PH_HEAD: if (ev.head_take) nxt = PH_BODY;
            PH_BODY: if (ev.tail_take) nxt = PH_RESP;
            PH_RESP: if (ev.resp_take) nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/wr2pkt_phase.sv
module wr2pkt_phase
    import wr2pkt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  wr_events_t ev,
    output wr_phase_e  phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_step(phase, ev);
        end
    end

endmodule

// File: rtl/wr2pkt_capture.sv
module wr2pkt_capture #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned ID_W   = 4,
    parameter int unsigned LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ID_W-1:0]   in_id,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LEN_W-1:0]  in_len,
    output logic [ID_W-1:0]   held_id,
    output logic [ADDR_W-1:0] held_addr,
    output logic [LEN_W-1:0]  held_len
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_id   <= '0;
            held_addr <= '0;
            held_len  <= '0;
        end else if (load) begin
            held_id   <= in_id;
            held_addr <= in_addr;
            held_len  <= in_len;
        end
    end

endmodule

// File: rtl/wr2pkt_header.sv
module wr2pkt_header #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned ID_W   = 4,
    parameter int unsigned LEN_W  = 8,
    parameter int unsigned DEST_W = 4
) (
    input  logic [ID_W-1:0]   id,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    output logic [DATA_W-1:0] word
);

    localparam int unsigned HDR_W = DEST_W + ID_W + LEN_W + ADDR_W;

    logic [DEST_W-1:0] dest;
    logic [HDR_W-1:0]  packed_fields;

    assign dest          = addr[ADDR_W-1 -: DEST_W];
    assign packed_fields = {dest, id, len, addr};

    generate
        if (HDR_W < DATA_W) begin : g_pad
            assign word = {{(DATA_W-HDR_W){1'b0}}, packed_fields};
        end else begin : g_trim
            assign word = packed_fields[DATA_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/wr2pkt_bridge.sv
module wr2pkt_bridge
    import wr2pkt_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned ID_W   = DEF_ID_W,
    parameter int unsigned LEN_W  = DEF_LEN_W,
    parameter int unsigned DEST_W = DEF_DEST_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic [ID_W-1:0]   aw_id,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic [LEN_W-1:0]  aw_len,
    input  logic              w_valid,
    output logic              w_ready,
    input  logic [DATA_W-1:0] w_data,
    input  logic              w_last,
    output logic              b_valid,
    input  logic              b_ready,
    output logic [ID_W-1:0]   b_id,
    output logic [1:0]        b_resp,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    output logic [DATA_W-1:0] pkt_data,
    output logic              pkt_sop,
    output logic              pkt_eop
);

    wr_phase_e         phase;
    wr_events_t        ev;
    logic              in_idle, in_head, in_body, in_resp;
    logic [ID_W-1:0]   cap_id;
    logic [ADDR_W-1:0] cap_addr;
    logic [LEN_W-1:0]  cap_len;
    logic [DATA_W-1:0] hdr_word;

    assign in_idle = (phase == PH_IDLE);
    assign in_head = (phase == PH_HEAD);
    assign in_body = (phase == PH_BODY);
    assign in_resp = (phase == PH_RESP);

    always_comb begin
        ev.addr_take = aw_valid & in_idle;
        ev.head_take = in_head & pkt_ready;
        ev.tail_take = in_body & w_valid & pkt_ready & w_last;
        ev.resp_take = in_resp & b_ready;
    end

    wr2pkt_phase u_phase (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .phase (phase)
    );

    wr2pkt_capture #(
        .ADDR_W (ADDR_W),
        .ID_W   (ID_W),
        .LEN_W  (LEN_W)
    ) u_capture (
        .clk       (clk),
        .rst       (rst),
        .load      (ev.addr_take),
        .in_id     (aw_id),
        .in_addr   (aw_addr),
        .in_len    (aw_len),
        .held_id   (cap_id),
        .held_addr (cap_addr),
        .held_len  (cap_len)
    );

    wr2pkt_header #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .ID_W   (ID_W),
        .LEN_W  (LEN_W),
        .DEST_W (DEST_W)
    ) u_header (
        .id   (cap_id),
        .addr (cap_addr),
        .len  (cap_len),
        .word (hdr_word)
    );

    // Address channel: open only between writes
    assign aw_ready = in_idle;

    // Data channel: cut-through, closed until the header is gone
    assign w_ready   = in_body & pkt_ready;
    assign pkt_valid = in_head | (in_body & w_valid);
    assign pkt_sop   = in_head;
    assign pkt_eop   = in_body & w_last;
    assign pkt_data  = in_head ? hdr_word : w_data;

    // Response channel
    assign b_valid = in_resp;
    assign b_id    = cap_id;
    assign b_resp  = RESP_OKAY;

    // R3: a header waiting on the network stays put
    p_head_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && pkt_sop && !pkt_ready) |=> (pkt_valid && pkt_sop && $stable(pkt_data)));

    // R4: no data beat is taken while a header is on the output
    p_no_data_under_head_r4: assert property (@(posedge clk) disable iff (rst)
        w_ready |-> !pkt_sop);

    // R5: an accepted data beat is the word the network takes
    p_cut_through_r5: assert property (@(posedge clk) disable iff (rst)
        (w_valid && w_ready) |-> (pkt_valid && pkt_ready && !pkt_sop && pkt_data == w_data));

    // R6: a response appears only after an end-of-packet handshake
    p_resp_after_eop_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(b_valid) |-> $past(pkt_valid && pkt_ready && pkt_eop));

    // R7: a pending response holds its ID
    p_resp_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (b_valid && !b_ready) |=> (b_valid && $stable(b_id)));

    // R2: one write at a time
    p_single_write_r2: assert property (@(posedge clk) disable iff (rst)
        aw_ready |-> (!b_valid && !pkt_valid));

    // R8: network stall closes the data channel
    p_net_stall_r8: assert property (@(posedge clk) disable iff (rst)
        !pkt_ready |-> !w_ready);

endmodule

// File: tb/tb_wr2pkt_bridge.sv
`timescale 1ns/1ps
module tb_wr2pkt_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        aw_valid = 1'b0;
    logic        aw_ready;
    logic [3:0]  aw_id = '0;
    logic [31:0] aw_addr = '0;
    logic [7:0]  aw_len = '0;
    logic        w_valid = 1'b0;
    logic        w_ready;
    logic [63:0] w_data = '0;
    logic        w_last = 1'b0;
    logic        b_valid;
    logic        b_ready = 1'b0;
    logic [3:0]  b_id;
    logic [1:0]  b_resp;
    logic        pkt_valid;
    logic        pkt_ready = 1'b0;
    logic [63:0] pkt_data;
    logic        pkt_sop;
    logic        pkt_eop;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    wr2pkt_bridge dut (
        .clk(clk), .rst(rst),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
        .aw_addr(aw_addr), .aw_len(aw_len),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_last(w_last),
        .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
        .pkt_sop(pkt_sop), .pkt_eop(pkt_eop)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_header(input logic [3:0] id, input logic [31:0] addr,
                                               input logic [7:0] len);
        logic [63:0] h;
        h = '0;
        h[31:0]  = addr;
        h[39:32] = len;
        h[43:40] = id;
        h[47:44] = addr[31:28];
        return h;
    endfunction

    function automatic logic [63:0] beat_word(input logic [31:0] addr, input logic [3:0] id, input int i);
        return {addr, 16'h5A00, 4'h0, id, i[7:0]};
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 aw_ready in reset", {63'b0, aw_ready}, 64'd1);
        chk("R1 pkt_valid in reset", {63'b0, pkt_valid}, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk("R1 aw_ready after reset", {63'b0, aw_ready}, 64'd1);
        chk("R1 w_ready after reset", {63'b0, w_ready}, 64'd0);
        chk("R1 b_valid after reset", {63'b0, b_valid}, 64'd0);
        chk("R1 pkt_valid after reset", {63'b0, pkt_valid}, 64'd0);
    endtask

    // One complete write with selectable stalls on each channel
    task automatic run_write(input logic [3:0] id, input logic [31:0] addr, input logic [7:0] len,
                             input bit early_w, input int head_stall, input int mid_stall,
                             input int resp_stall);
        logic [63:0] hdr;
        int nbeats;
        hdr    = exp_header(id, addr, len);
        nbeats = int'(len) + 1;

        @(negedge clk);
        aw_valid  = 1'b1;
        aw_id     = id;
        aw_addr   = addr;
        aw_len    = len;
        pkt_ready = 1'b0;
        b_ready   = 1'b0;
        if (early_w) begin
            w_valid = 1'b1;
            w_data  = beat_word(addr, id, 0);
            w_last  = (nbeats == 1);
        end
        #1;
        chk("R2 aw_ready open when idle", {63'b0, aw_ready}, 64'd1);
        if (early_w) chk("R4 data before address held", {63'b0, w_ready}, 64'd0);

        @(negedge clk);
        aw_valid = 1'b0;
        aw_id    = ~id;
        aw_addr  = ~addr;
        aw_len   = ~len;
        #1;
        chk("R2 aw_ready closed after accept", {63'b0, aw_ready}, 64'd0);
        chk("R3 header valid", {63'b0, pkt_valid}, 64'd1);
        chk("R3 header sop/eop", {62'b0, pkt_sop, pkt_eop}, 64'd2);
        chk("R3 header word", pkt_data, hdr);
        chk("R4 data closed under header", {63'b0, w_ready}, 64'd0);

        for (int s = 0; s < head_stall; s++) begin
            @(negedge clk);
            #1;
            chk("R3 header held during stall", pkt_data, hdr);
            chk("R3 header valid during stall", {63'b0, pkt_valid}, 64'd1);
            chk("R4 data closed during header stall", {63'b0, w_ready}, 64'd0);
        end
        pkt_ready = 1'b1;
        @(negedge clk);

        for (int i = 0; i < nbeats; i++) begin
            w_valid = 1'b1;
            w_data  = beat_word(addr, id, i);
            w_last  = (i == nbeats - 1);
            if (i == mid_stall) begin
                pkt_ready = 1'b0;
                #1;
                chk("R8 data closed on network stall", {63'b0, w_ready}, 64'd0);
                @(negedge clk);
                pkt_ready = 1'b1;
            end
            #1;
            chk("R5 payload valid", {63'b0, pkt_valid}, 64'd1);
            chk("R5 payload word", pkt_data, beat_word(addr, id, i));
            chk("R5 data ready follows network", {63'b0, w_ready}, 64'd1);
            chk("R6 sop/eop on payload", {62'b0, pkt_sop, pkt_eop}, {62'b0, 1'b0, (i == nbeats - 1)});
            @(negedge clk);
        end
        w_valid   = 1'b0;
        w_last    = 1'b0;
        pkt_ready = 1'b0;
        #1;
        chk("R6 response raised", {63'b0, b_valid}, 64'd1);
        chk("R6 response id", {60'b0, b_id}, {60'b0, id});
        chk("R6 response OKAY", {62'b0, b_resp}, 64'd0);
        chk("R2 aw_ready closed during response", {63'b0, aw_ready}, 64'd0);

        for (int s = 0; s < resp_stall; s++) begin
            aw_valid = 1'b1;
            @(negedge clk);
            #1;
            chk("R7 response held", {59'b0, b_valid, b_id}, {59'b0, 1'b1, id});
            chk("R2 new address refused", {63'b0, aw_ready}, 64'd0);
        end
        aw_valid = 1'b0;
        b_ready  = 1'b1;
        @(negedge clk);
        b_ready = 1'b0;
        #1;
        chk("R7 response dropped", {63'b0, b_valid}, 64'd0);
        chk("R7 address reopened", {63'b0, aw_ready}, 64'd1);
    endtask

    task automatic t_single();     run_write(4'h3, 32'h1000_0040, 8'd0, 1'b0, 0, -1, 0); endtask
    task automatic t_head_stall(); run_write(4'h5, 32'h7ABC_0000, 8'd3, 1'b0, 3, -1, 0); endtask
    task automatic t_data_first(); run_write(4'h9, 32'h2000_0100, 8'd1, 1'b1, 1, -1, 0); endtask
    task automatic t_net_stall();  run_write(4'hC, 32'h3456_0008, 8'd2, 1'b0, 0, 1, 2); endtask
    task automatic t_top_dest();   run_write(4'hF, 32'hF000_FFFC, 8'd0, 1'b1, 0, 0, 1); endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1-R8 run actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_single();
        t_head_stall();
        t_data_first();
        t_net_stall();
        t_top_dest();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule